// File: doc/BRIEF.md
# Multiply-Divide Unit with Dedicated Result Registers

This unit performs 32-bit integer multiplication and division for a core whose general register file offers only two read ports and one write port per instruction. Results do not return to that file. They go to two private registers, a high word and a low word, and the core later moves them out with explicit read commands. Each command supplies at most two source words. A full-width dividend that spans both registers is therefore not accepted.

The result registers are overwritten as soon as a multiply or divide is accepted, and they serve as the working storage for the iteration. Because of this, a command that modifies them must not follow a read of them too closely. The unit enforces this rule. If a modifying command arrives in the cycle right after an accepted read, the unit flags it and drops it. A multiply takes four iteration cycles, using an 8-bit-per-cycle shift-add. A divide takes 32 iteration cycles, using radix-2 restoring steps. The two overflow cases of division finish at once and are reported on status outputs.

Top module: `muldiv_unit`

## Requirements
- R1: Commands are coded on `cmd_op` as follows: 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 read high, 5 read low, 6 write high, 7 write low. An accepted read presents the selected register on `rd_data` with `ready` high.
- R2: A multiply leaves the upper half of the 64-bit product in the high register and the lower half in the low register. `busy` is high for exactly 4 cycles after the start edge.
- R3: A divide leaves the quotient in the low register and the remainder in the high register. The signed remainder takes the sign of the dividend. `busy` is high for exactly 32 cycles after the start edge.
- R4: The result registers are overwritten at the start edge, so their previous contents are lost even if the operation never finishes.
- R5: A read issued while `busy` is high holds `ready` low until the operation ends, then returns the final result.
- R6: A modifying command (codes 0-3, 6, 7) presented in the cycle right after an accepted read raises `hazard` and is ignored. The same command is accepted one cycle later.
- R7: A divide with a zero divisor finishes at once without `busy`. It sets `div_zero`, writes all-ones to the low register and the dividend to the high register. The next accepted modifying command clears the flag.
- R8: A signed divide of the most negative value by -1 finishes at once. It sets `div_ovf` and leaves the most negative value as quotient and zero as remainder. The same operands as an unsigned divide give quotient 0 and remainder 0x80000000 without the flag.
- R9: Write high and write low load `src_a` into the chosen register in one cycle. A write while `busy` is high ends the operation in progress, and `busy` is low on the next cycle.
- R10: After reset both registers read zero, and `busy`, `div_zero` and `div_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | Command code |
| src_a | input | 32 | First source word (multiplicand, dividend or write data) |
| src_b | input | 32 | Second source word (multiplier or divisor) |
| ready | output | 1 | Low while a read is stalled behind a running operation |
| hazard | output | 1 | The presented modifying command breaks the read gap and is dropped |
| busy | output | 1 | A multiply or divide is iterating |
| div_zero | output | 1 | The last started divide had a zero divisor |
| div_ovf | output | 1 | The last started divide was most-negative by -1 |
| rd_data | output | 32 | Selected result register for read commands |

## Verification
The working state lives in the result registers themselves. A wrong step count, a lost sign fix or a wrong restore decision therefore shows up in the value returned by the first read after `busy` falls, which is 4 or 32 cycles after the start. A bad read-gap tracker is visible on `hazard` in the very cycle of the offending command. Its effect, a dropped or wrongly accepted write, appears on the next read of that register. The immediate overflow paths show on `busy`, `div_zero` and `div_ovf` one cycle after the start edge.

// File: rtl/muldiv_unit.sv
`timescale 1ns/1ps
module muldiv_unit #(
  parameter int W = 32,
  parameter int MUL_STEPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  input  logic [2:0]   cmd_op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         ready,
  output logic         hazard,
  output logic         busy,
  output logic         div_zero,
  output logic         div_ovf,
  output logic [W-1:0] rd_data
);
  localparam int CH = W / MUL_STEPS;
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [2:0] OP_MULS = 3'd0, OP_MULU = 3'd1, OP_DIVS = 3'd2, OP_DIVU = 3'd3,
                         OP_RDHI = 3'd4, OP_RDLO = 3'd5, OP_WRHI = 3'd6, OP_WRLO = 3'd7;

  logic [W-1:0]  hi, lo, opnd;
  logic [CW-1:0] cnt;
  logic          run_div, neg_q, neg_r, rd_recent;

  logic is_read, is_mod, is_mul, is_div, sgn, acc_mod, b_zero, ovf_case, last;
  logic [W-1:0] abs_a, abs_b;

  assign is_read  = (cmd_op == OP_RDHI) || (cmd_op == OP_RDLO);
  assign is_mod   = !is_read;
  assign is_mul   = (cmd_op == OP_MULS) || (cmd_op == OP_MULU);
  assign is_div   = (cmd_op == OP_DIVS) || (cmd_op == OP_DIVU);
  assign sgn      = (cmd_op == OP_MULS) || (cmd_op == OP_DIVS);
  assign hazard   = cmd_valid && is_mod && rd_recent;
  assign acc_mod  = cmd_valid && is_mod && !rd_recent;
  assign ready    = !(cmd_valid && is_read && busy);
  assign rd_data  = (cmd_op == OP_RDHI) ? hi : lo;
  assign abs_a    = (sgn && src_a[W-1]) ? -src_a : src_a;
  assign abs_b    = (sgn && src_b[W-1]) ? -src_b : src_b;
  assign b_zero   = (src_b == '0);
  assign ovf_case = (cmd_op == OP_DIVS) && (src_a == MINV) && (src_b == '1);
  assign last     = (cnt == CW'(1));

  // multiply step: one CH-bit slice of the multiplier per cycle
  logic [W+CH-1:0] macc;
  logic [2*W-1:0]  mprod, mnext;
  assign macc  = {{CH{1'b0}}, hi} + ({{W{1'b0}}, lo[CH-1:0]} * {{CH{1'b0}}, opnd});
  assign mprod = {macc, lo[W-1:CH]};
  assign mnext = (last && neg_q) ? -mprod : mprod;

  // restoring divide step
  logic [W:0]   dtry;
  logic         dge;
  logic [W-1:0] rem_n, quo_n;
  assign dtry  = {hi, lo[W-1]} - {1'b0, opnd};
  assign dge   = !dtry[W];
  assign rem_n = dge ? dtry[W-1:0] : {hi[W-2:0], lo[W-1]};
  assign quo_n = {lo[W-2:0], dge};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi <= '0; lo <= '0; opnd <= '0; cnt <= '0;
      busy <= 1'b0; run_div <= 1'b0; neg_q <= 1'b0; neg_r <= 1'b0;
      rd_recent <= 1'b0; div_zero <= 1'b0; div_ovf <= 1'b0;
    end else begin
      rd_recent <= cmd_valid && is_read && !busy;
      if (acc_mod) begin
        div_zero <= is_div && b_zero;
        div_ovf  <= is_div && ovf_case;
        if (is_mul) begin
          hi <= '0; lo <= abs_b; opnd <= abs_a;
          neg_q <= sgn && (src_a[W-1] ^ src_b[W-1]);
          run_div <= 1'b0; busy <= 1'b1; cnt <= CW'(MUL_STEPS);
        end else if (is_div) begin
          if (b_zero) begin
            hi <= src_a; lo <= '1; busy <= 1'b0;
          end else if (ovf_case) begin
            hi <= '0; lo <= MINV; busy <= 1'b0;
          end else begin
            hi <= '0; lo <= abs_a; opnd <= abs_b;
            neg_q <= sgn && (src_a[W-1] ^ src_b[W-1]);
            neg_r <= sgn && src_a[W-1];
            run_div <= 1'b1; busy <= 1'b1; cnt <= CW'(W);
          end
        end else if (cmd_op == OP_WRHI) begin
          hi <= src_a; busy <= 1'b0;
        end else begin
          lo <= src_a; busy <= 1'b0;
        end
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (last) busy <= 1'b0;
        if (run_div) begin
          hi <= (last && neg_r) ? -rem_n : rem_n;
          lo <= (last && neg_q) ? -quo_n : quo_n;
        end else begin
          hi <= mnext[2*W-1:W];
          lo <= mnext[W-1:0];
        end
      end
    end
  end

  // R6
  hazard_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hazard |=> ($stable(hi) && $stable(lo) && !busy));

  // R2
  mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !hazard && is_mul) |=> busy);

  // R7
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !hazard && is_div && src_b == '0) |=>
      (div_zero && !busy && lo == '1 && hi == $past(src_a)));

  // R8
  div_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !hazard && cmd_op == OP_DIVS && src_a == MINV && src_b == '1) |=>
      (div_ovf && !busy && lo == MINV && hi == '0));

  // R9
  write_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !hazard && cmd_op == OP_WRHI) |=> (hi == $past(src_a) && !busy));

  // R5
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> busy);
endmodule

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [31:0] src_a = '0, src_b = '0;
  logic ready, hazard, busy, div_zero, div_ovf;
  logic [31:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [2:0] MULS = 3'd0, MULU = 3'd1, DIVS = 3'd2, DIVU = 3'd3,
                         RDHI = 3'd4, RDLO = 3'd5, WRHI = 3'd6, WRLO = 3'd7;

  always #2 clk = ~clk;

  muldiv_unit u_muldiv_unit (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .src_a(src_a), .src_b(src_b), .ready(ready), .hazard(hazard), .busy(busy),
    .div_zero(div_zero), .div_ovf(div_ovf), .rd_data(rd_data));

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic put(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; src_a = a; src_b = b;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] op, input bit idle, output logic [31:0] d, output bit stalled);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    #1;
    stalled = !ready;
    while (!ready) begin @(posedge clk); #1; end
    d = rd_data;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    if (idle) begin @(posedge clk); #1; end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(posedge clk); #1; end
  endtask

  task automatic t_reset;
    logic [31:0] d; bit s;
    check("R10 busy", busy, 0);
    check("R10 div_zero", div_zero, 0);
    check("R10 div_ovf", div_ovf, 0);
    rd(RDHI, 1, d, s); check("R10/R1 hi", d, 0);
    rd(RDLO, 1, d, s); check("R10/R1 lo", d, 0);
  endtask

  task automatic t_mul(input bit sg, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] ea, eb, p; logic [31:0] d; bit s; int n;
    ea = sg ? {{32{a[31]}}, a} : {32'b0, a};
    eb = sg ? {{32{b[31]}}, b} : {32'b0, b};
    p = ea * eb;
    put(sg ? MULS : MULU, a, b);
    count_busy(n);
    check("R2 mul busy cycles", n, 4);
    rd(RDHI, 1, d, s); check("R2 mul hi", d, p[63:32]);
    rd(RDLO, 1, d, s); check("R2 mul lo", d, p[31:0]);
  endtask

  task automatic t_div(input bit sg, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] q, r, d; bit s; int n;
    if (sg) begin q = $signed(a) / $signed(b); r = $signed(a) % $signed(b); end
    else begin q = a / b; r = a % b; end
    put(sg ? DIVS : DIVU, a, b);
    count_busy(n);
    check("R3 div busy cycles", n, 32);
    rd(RDLO, 1, d, s); check("R3 quotient", d, q);
    rd(RDHI, 1, d, s); check("R3 remainder", d, r);
  endtask

  task automatic t_stall;
    logic [31:0] d; bit s;
    put(MULU, 32'h0001_0000, 32'h0003_0000);
    rd(RDHI, 1, d, s);
    check("R5 ready low while busy", s, 1);
    check("R5 final hi", d, 32'h3);
  endtask

  task automatic t_hazard;
    logic [31:0] d; bit s;
    put(WRLO, 32'h11, 0);
    rd(RDHI, 0, d, s);
    cmd_valid = 1'b1; cmd_op = WRLO; src_a = 32'h99;
    #0.5;
    check("R6 hazard raised", hazard, 1);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    @(posedge clk); #1;
    rd(RDLO, 1, d, s); check("R6 dropped write", d, 32'h11);
    rd(RDHI, 0, d, s);
    @(posedge clk); #1;
    cmd_valid = 1'b1; cmd_op = WRLO; src_a = 32'h77;
    #0.5;
    check("R6 no hazard at gap two", hazard, 0);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    rd(RDLO, 1, d, s); check("R6 accepted write", d, 32'h77);
  endtask

  task automatic t_divzero;
    logic [31:0] d; bit s;
    put(DIVS, 32'hFFFF_FFFB, 0);
    check("R7 no busy", busy, 0);
    check("R7 div_zero set", div_zero, 1);
    rd(RDLO, 1, d, s); check("R7 quotient ones", d, 32'hFFFF_FFFF);
    rd(RDHI, 1, d, s); check("R7 remainder dividend", d, 32'hFFFF_FFFB);
    put(WRHI, 32'h5, 0);
    check("R7 flag cleared", div_zero, 0);
  endtask

  task automatic t_ovf;
    logic [31:0] d; bit s; int n;
    put(DIVS, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R8 no busy", busy, 0);
    check("R8 div_ovf set", div_ovf, 1);
    rd(RDLO, 1, d, s); check("R8 quotient", d, 32'h8000_0000);
    rd(RDHI, 1, d, s); check("R8 remainder", d, 0);
    put(DIVU, 32'h8000_0000, 32'hFFFF_FFFF);
    check("R8 unsigned no flag", div_ovf, 0);
    count_busy(n);
    rd(RDLO, 1, d, s); check("R8 unsigned quotient", d, 0);
    rd(RDHI, 1, d, s); check("R8 unsigned remainder", d, 32'h8000_0000);
  endtask

  task automatic t_abort;
    logic [31:0] d; bit s;
    put(WRHI, 32'hDEAD_BEEF, 0);
    rd(RDHI, 1, d, s); check("R9 write hi", d, 32'hDEAD_BEEF);
    put(MULU, 32'd3, 32'd5);
    put(WRLO, 32'h1234, 0);
    check("R9 abort clears busy", busy, 0);
    rd(RDLO, 1, d, s); check("R9 write lo", d, 32'h1234);
    rd(RDHI, 1, d, s); check("R4 old hi lost at start", d, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_mul(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    t_mul(1, 32'hFFFF_FFFD, 32'd7);
    t_mul(1, 32'h8000_0000, 32'h8000_0000);
    t_mul(0, 32'h1234_5678, 32'h9ABC_DEF0);
    t_div(0, 32'd100, 32'd7);
    t_div(0, 32'hFFFF_FFF0, 32'd7);
    t_div(1, 32'hFFFF_FFF9, 32'd2);
    t_div(1, 32'hFFFF_FF9C, 32'hFFFF_FFF9);
    t_div(1, 32'd100, 32'hFFFF_FFF9);
    t_stall();
    t_hazard();
    t_divzero();
    t_ovf();
    t_abort();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule